// File: doc/BRIEF.md
# Byte-Granular Register File Burst Mover

This block copies bytes between a 32-entry, 32-bit register file and a byte-wide memory port. It treats the register file as one flat byte array. Byte k of register n sits at flat position 4n+k, and bits [7:0] are byte 0. A command names five things: the direction, the flat byte position where the transfer starts, a base register, an unsigned immediate offset and a byte count. The transfer can start at any byte inside a register. It then walks upward one flat position per byte and crosses register boundaries freely. On the memory side, the first address is the value of the base register plus the offset, and each later byte uses the next address up.

A direct word port reads and writes whole registers. Software uses it to prepare operands and to inspect results. A controller with three states sequences the engine. ST_IDLE accepts a command. A legal command takes the transition IDLE->XFER. An illegal one stays in ST_IDLE and raises the error pulse. ST_XFER moves one byte on each memory handshake. It holds its state while the memory stalls and takes XFER->FIN on the handshake of the final byte. ST_FIN lasts one cycle, drives the completion pulse and returns to ST_IDLE through FIN->IDLE.

Top module: `byte_burst_engine`

## Requirements
- R1: After reset, busy, done, err, mem_req and mem_we are low and every register reads as zero.
- R2: Register byte k (bits 8k+7..8k) of register n occupies flat byte position 4n+k.
- R3: Byte i of a burst uses flat register position start+i, continuing from byte 3 of one register into byte 0 of the next.
- R4: Byte i of a burst uses memory address base_value+offset+i, where the offset is zero-extended.
- R5: A store (cmd_store=1) drives mem_we high and puts the register byte on mem_wdata. For example, with R0=0x80818283, R1=0x84858687 and R2=0x1000, a store of 5 bytes from position 2 with base R2 and offset 0 writes 81, 80, 87, 86, 85 to addresses 0x1000 to 0x1004.
- R6: A load (cmd_store=0) writes mem_rdata into register position start+i on each handshake and leaves every other register byte unchanged.
- R7: The base register value is captured when the command is accepted. A load that overwrites the base register does not change the later addresses of the same burst.
- R8: A byte completes only in a cycle where mem_req and mem_ready are both high. While mem_ready is low, the address, direction and register position are held.
- R9: Commands are accepted only in ST_IDLE. A cmd_valid raised while busy is high has no effect.
- R10: A command is rejected when its count is 0, its count exceeds 124, or start+count exceeds 128. A rejected command raises err for exactly one cycle, keeps busy low and moves no byte.
- R11: busy is high from the cycle after acceptance through the done cycle. done is high for exactly one cycle, the cycle after the last handshake.
- R12: dir_rdata shows register dir_idx combinationally. A dir_we write lands only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_store | input | 1 | 1 = register to memory, 0 = memory to register |
| cmd_rbyte | input | 7 | Flat register byte position of the first byte |
| cmd_base | input | 5 | Index of the base register |
| cmd_imm | input | 16 | Unsigned immediate memory offset |
| cmd_count | input | 7 | Number of bytes |
| busy | output | 1 | Burst in progress (ST_XFER or ST_FIN) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Load data |
| mem_ready | input | 1 | Memory completes the current byte |
| dir_we | input | 1 | Direct word write enable |
| dir_idx | input | 5 | Direct port register index |
| dir_wdata | input | 32 | Direct write data |
| dir_rdata | output | 32 | Direct read data |

## Verification
A command is driven on a falling edge and sampled on the next rising edge. busy is therefore due at the following falling edge, and err is due there too when the command is illegal. From then on, the request and address for byte i are visible one cycle after the handshake of byte i-1. A load result sits in the register from the edge of its handshake onward. The bench holds a behavioural byte model of the registers and of memory. On every falling edge of a burst it compares the request, direction, address and store data against that model, and it decides mem_ready at the same edge. It expects done exactly one falling edge after the last accepted handshake. It reads the whole register file back through the direct port, one index per cycle, after the bursts.

// File: rtl/bbe_pkg.sv
package bbe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } bbe_state_t;
endpackage

// File: rtl/bbe_regfile.sv
module bbe_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          w_we,
    input  logic [$clog2(NREGS)-1:0]      w_idx,
    input  logic [XLEN-1:0]               w_data,
    input  logic [$clog2(NREGS)-1:0]      ra_idx,
    output logic [XLEN-1:0]               ra_data,
    input  logic [$clog2(NREGS)-1:0]      rb_idx,
    output logic [XLEN-1:0]               rb_data,
    input  logic                          b_we,
    input  logic [$clog2(NREGS*XLEN/8)-1:0] b_addr,
    input  logic [7:0]                    b_wdata,
    output logic [7:0]                    b_rdata
);
    localparam int BPW   = XLEN / 8;
    localparam int BYTES = NREGS * BPW;
    localparam int BA_W  = $clog2(BYTES);
    localparam int RI_W  = $clog2(NREGS);

    logic [7:0] bytes_q [BYTES];

    function automatic logic [BA_W-1:0] flat(input logic [RI_W-1:0] idx, input int k);
        return BA_W'(int'(idx) * BPW + k);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) bytes_q[i] <= '0;
        end else begin
            if (w_we) begin
                for (int k = 0; k < BPW; k++) bytes_q[flat(w_idx, k)] <= w_data[8*k +: 8];
            end
            if (b_we) bytes_q[b_addr] <= b_wdata;
        end
    end

    for (genvar k = 0; k < BPW; k++) begin : g_lane
        assign ra_data[8*k +: 8] = bytes_q[flat(ra_idx, k)];
        assign rb_data[8*k +: 8] = bytes_q[flat(rb_idx, k)];
    end

    assign b_rdata = bytes_q[b_addr];

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        w_we |-> !b_we) else $error("word and byte write collide"); // R12
endmodule

// File: rtl/bbe_ctrl.sv
module bbe_ctrl
    import bbe_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int BYTES   = 128,
    parameter int OFF_W   = 16,
    parameter int MAX_CNT = 124
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic                     cmd_store,
    input  logic [$clog2(BYTES)-1:0] cmd_rbyte,
    input  logic [XLEN-1:0]          cmd_base_val,
    input  logic [OFF_W-1:0]         cmd_imm,
    input  logic [$clog2(BYTES)-1:0] cmd_count,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [XLEN-1:0]          mem_addr,
    output logic [7:0]               mem_wdata,
    input  logic [7:0]               mem_rdata,
    input  logic                     mem_ready,
    output logic [$clog2(BYTES)-1:0] rf_baddr,
    output logic                     rf_bwe,
    output logic [7:0]               rf_bwdata,
    input  logic [7:0]               rf_brdata
);
    localparam int BA_W = $clog2(BYTES);

    bbe_state_t      state_q, state_d;
    logic [BA_W-1:0] rptr_q, left_q;
    logic [XLEN-1:0] maddr_q;
    logic            store_q, err_q;
    logic [BA_W:0]   span;
    logic            legal, accept, hs, last;

    assign span   = {1'b0, cmd_rbyte} + {1'b0, cmd_count};
    assign legal  = (cmd_count != '0) && (int'(cmd_count) <= MAX_CNT) && (int'(span) <= BYTES);
    assign accept = cmd_valid && (state_q == ST_IDLE);
    assign hs     = mem_req && mem_ready;
    assign last   = (left_q == BA_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && legal) state_d = ST_XFER;
            ST_XFER: if (hs && last)      state_d = ST_FIN;
            ST_FIN:                       state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = store_q;
            end
            ST_FIN: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            left_q  <= '0;
            maddr_q <= '0;
            store_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= accept && !legal;
            if (accept && legal) begin
                rptr_q  <= cmd_rbyte;
                left_q  <= cmd_count;
                maddr_q <= cmd_base_val + XLEN'(cmd_imm);
                store_q <= cmd_store;
            end else if (hs) begin
                rptr_q  <= rptr_q + BA_W'(1);
                left_q  <= left_q - BA_W'(1);
                maddr_q <= maddr_q + XLEN'(1);
            end
        end
    end

    assign err       = err_q;
    assign mem_addr  = maddr_q;
    assign mem_wdata = rf_brdata;
    assign rf_baddr  = rptr_q;
    assign rf_bwe    = hs && !store_q;
    assign rf_bwdata = mem_rdata;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(rf_baddr)))
        else $error("stall not held"); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !last) |=> (mem_req && mem_addr == $past(mem_addr) + XLEN'(1)))
        else $error("memory address did not step"); // R4
    AST_RBYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !last) |=> (rf_baddr == $past(rf_baddr) + BA_W'(1)))
        else $error("register position did not step"); // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && last) |=> (done && busy && !mem_req))
        else $error("done missing after last byte"); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R11
    AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !mem_req)) else $error("rejected command moved"); // R10
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !$past(accept)) |-> 1'b0) else $error("err without a command"); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_bwe)) else $error("activity while idle"); // R9
endmodule

// File: rtl/byte_burst_engine.sv
module byte_burst_engine #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cmd_valid,
    input  logic                                cmd_store,
    input  logic [$clog2(NREGS*XLEN/8)-1:0]     cmd_rbyte,
    input  logic [$clog2(NREGS)-1:0]            cmd_base,
    input  logic [OFF_W-1:0]                    cmd_imm,
    input  logic [$clog2(NREGS*XLEN/8)-1:0]     cmd_count,
    output logic                                busy,
    output logic                                done,
    output logic                                err,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [XLEN-1:0]                     mem_addr,
    output logic [7:0]                          mem_wdata,
    input  logic [7:0]                          mem_rdata,
    input  logic                                mem_ready,
    input  logic                                dir_we,
    input  logic [$clog2(NREGS)-1:0]            dir_idx,
    input  logic [XLEN-1:0]                     dir_wdata,
    output logic [XLEN-1:0]                     dir_rdata
);
    localparam int BPW     = XLEN / 8;
    localparam int BYTES   = NREGS * BPW;
    localparam int BA_W    = $clog2(BYTES);
    localparam int MAX_CNT = BYTES - BPW;

    logic [XLEN-1:0] base_val;
    logic [BA_W-1:0] rf_baddr;
    logic            rf_bwe;
    logic [7:0]      rf_bwdata, rf_brdata;

    bbe_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_we    (dir_we && !busy),
        .w_idx   (dir_idx),
        .w_data  (dir_wdata),
        .ra_idx  (dir_idx),
        .ra_data (dir_rdata),
        .rb_idx  (cmd_base),
        .rb_data (base_val),
        .b_we    (rf_bwe),
        .b_addr  (rf_baddr),
        .b_wdata (rf_bwdata),
        .b_rdata (rf_brdata)
    );

    bbe_ctrl #(.XLEN(XLEN), .BYTES(BYTES), .OFF_W(OFF_W), .MAX_CNT(MAX_CNT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_store    (cmd_store),
        .cmd_rbyte    (cmd_rbyte),
        .cmd_base_val (base_val),
        .cmd_imm      (cmd_imm),
        .cmd_count    (cmd_count),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ready    (mem_ready),
        .rf_baddr     (rf_baddr),
        .rf_bwe       (rf_bwe),
        .rf_bwdata    (rf_bwdata),
        .rf_brdata    (rf_brdata)
    );
endmodule

// File: tb/byte_burst_engine_tb.sv
`timescale 1ns/1ps
module byte_burst_engine_tb;
    localparam int MASK = 1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_store = 1'b0;
    logic [6:0]  cmd_rbyte = '0, cmd_count = '0;
    logic [4:0]  cmd_base = '0;
    logic [15:0] cmd_imm = '0;
    logic        busy, done, err, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        dir_we = 1'b0;
    logic [4:0]  dir_idx = '0;
    logic [31:0] dir_wdata = '0, dir_rdata;

    logic [7:0]  bmem [MASK+1];
    logic [31:0] mreg [32];
    int n_checks = 0, n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[9:0]];

    byte_burst_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_rbyte(cmd_rbyte), .cmd_base(cmd_base), .cmd_imm(cmd_imm), .cmd_count(cmd_count),
        .busy(busy), .done(done), .err(err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dir_we(dir_we), .dir_idx(dir_idx), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] getb(input int a);
        return mreg[a / 4][(a % 4) * 8 +: 8];
    endfunction

    task automatic putb(input int a, input logic [7:0] v);
        mreg[a / 4][(a % 4) * 8 +: 8] = v;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    task automatic dwrite(input int idx, input logic [31:0] v);
        dir_we = 1'b1; dir_idx = 5'(idx); dir_wdata = v;
        @(negedge clk);
        dir_we = 1'b0;
        mreg[idx] = v;
    endtask

    task automatic check_regs(input string tag);
        for (int n = 0; n < 32; n++) begin
            dir_idx = 5'(n);
            @(negedge clk);
            chk(tag, dir_rdata, mreg[n]);
        end
    endtask

    task automatic burst(input bit st, input int rb, input int base, input int imm,
                         input int cnt, input bit stall, input bit poke);
        logic [31:0] a0;
        bit legal;
        int cyc;
        a0 = mreg[base] + 32'(imm);
        legal = (cnt >= 1) && (cnt <= 124) && (rb + cnt <= 128);
        cmd_valid = 1'b1; cmd_store = st; cmd_rbyte = 7'(rb); cmd_base = 5'(base);
        cmd_imm = 16'(imm); cmd_count = 7'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!legal) begin
            chk("R10 err pulse", {31'b0, err}, 32'd1);
            chk("R10 busy low", {31'b0, busy}, 32'd0);
            chk("R10 no request", {31'b0, mem_req}, 32'd0);
            @(negedge clk);
            chk("R10 err one cycle", {31'b0, err}, 32'd0);
            chk("R10 still idle", {31'b0, busy}, 32'd0);
            return;
        end
        chk("R11 busy after accept", {31'b0, busy}, 32'd1);
        cyc = 0;
        for (int i = 0; i < cnt; i++) begin
            bit rdy;
            do begin
                rdy = !stall || (cyc % 3 != 1);
                cyc++;
                mem_ready = rdy;
                if (poke && i == 1) begin
                    cmd_valid = 1'b1; cmd_store = ~st; cmd_rbyte = '0; cmd_count = 7'd1;
                    dir_we = 1'b1; dir_idx = 5'd31; dir_wdata = 32'hDEADBEEF;
                end
                chk("R8 request", {31'b0, mem_req}, 32'd1);
                chk("R11 busy in burst", {31'b0, busy}, 32'd1);
                chk("R4 address", mem_addr, a0 + 32'(i));
                chk("R5 direction", {31'b0, mem_we}, {31'b0, st});
                if (st) begin
                    chk("R3 R5 store byte", {24'b0, mem_wdata}, {24'b0, getb(rb + i)});
                    if (rdy) bmem[(a0 + 32'(i)) & MASK] = mem_wdata;
                end else if (rdy) begin
                    putb(rb + i, bmem[(a0 + 32'(i)) & MASK]);
                end
                @(negedge clk);
                cmd_valid = 1'b0; dir_we = 1'b0;
            end while (!rdy);
        end
        mem_ready = 1'b0;
        chk("R11 done pulse", {31'b0, done}, 32'd1);
        chk("R11 busy through done", {31'b0, busy}, 32'd1);
        chk("R11 no request at done", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        chk("R11 done one cycle", {31'b0, done}, 32'd0);
        chk("R9 idle after burst", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i <= MASK; i++) bmem[i] = 8'(i * 37 + 11);
        for (int n = 0; n < 32; n++) mreg[n] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 err", {31'b0, err}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 mem_we", {31'b0, mem_we}, 32'd0);
        check_regs("R1 reg reset");

        dwrite(0, 32'h80818283);
        dwrite(1, 32'h84858687);
        dwrite(2, 32'h00001000);
        dir_idx = 5'd1;
        @(negedge clk);
        chk("R12 direct read", dir_rdata, 32'h84858687);

        burst(1'b1, 2, 2, 0, 5, 1'b0, 1'b0);
        chk("R5 R2 example b0", {24'b0, bmem[0]}, 32'h81);
        chk("R5 R2 example b1", {24'b0, bmem[1]}, 32'h80);
        chk("R5 R2 example b2", {24'b0, bmem[2]}, 32'h87);
        chk("R5 R2 example b3", {24'b0, bmem[3]}, 32'h86);
        chk("R5 R2 example b4", {24'b0, bmem[4]}, 32'h85);

        burst(1'b0, 5, 2, 32'h20, 9, 1'b1, 1'b0);
        check_regs("R6 load only target bytes");

        dwrite(3, 32'h00000100);
        burst(1'b0, 12, 3, 3, 8, 1'b0, 1'b0);
        check_regs("R7 base captured");

        dwrite(31, 32'hA1B2C3D4);
        burst(1'b1, 124, 31, 5, 4, 1'b1, 1'b1);
        check_regs("R9 R12 ignored while busy");

        burst(1'b1, 0, 2, 0, 0, 1'b0, 1'b0);
        burst(1'b1, 0, 2, 0, 125, 1'b0, 1'b0);
        burst(1'b0, 125, 2, 0, 4, 1'b0, 1'b0);
        check_regs("R10 nothing moved");

        burst(1'b1, 0, 5, 17, 124, 1'b1, 1'b0);
        burst(1'b0, 3, 4, 600, 124, 1'b0, 1'b0);
        check_regs("R3 R6 long load");

        finish_run();
    end
endmodule